// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller for a small out-of-order execution core. It tracks a fixed set of functional units, by default four (integer, add, multiply and divide), and a register file of 32 entries. Each cycle it looks at the instruction at the head of an in-order queue and decides whether that instruction may enter its functional unit. It then tells each unit when to read its source operands and when it may write its result back. Issue stays in program order. Operand reads and write-backs happen whenever their hazards clear, so instructions may start and finish in any order.

Two tables hold the state. A per-unit status table keeps the operation, the destination and source registers, the producing unit for each source, and a ready flag for each source. A per-register table names the unit that will write that register, if any. Write-after-write hazards are resolved at issue. Read-after-write hazards are resolved when operands are read. Write-after-read hazards are resolved before write-back. There is no renaming: an instruction simply waits at its unit until its hazards clear.

Top module: `sb_ctrl`

## Requirements
- R1: `instr_ready_o` is high only when the unit selected by `instr_fu_i` is idle and either `instr_rd_i` is 0 or no active instruction will write `instr_rd_i`. An instruction is taken on a clock edge where `instr_valid_i` and `instr_ready_o` are both high. While a structural or write-after-write hazard holds `instr_ready_o` low, nothing is taken and no unit starts.
- R2: Register 0 never creates a hazard. An instruction with destination 0 may issue while other destination-0 instructions are active. A source of 0 is always available.
- R3: `start_o[i]` goes high for exactly one cycle once neither source of unit i's instruction has a pending producer. The earliest it can do so is the cycle after issue.
- R4: Operand-read starts may be granted out of program order. A later independent instruction may start while an earlier one is still waiting for an operand.
- R5: After `done_i[i]` is seen for a unit that is executing, that unit may receive `wr_grant_o[i]` no earlier than the next cycle. In the grant cycle, `wr_reg_o` carries that instruction's destination register. A unit never receives a grant without an earlier `done_i`.
- R6: A write grant is withheld while any other active instruction has a source equal to the grant's destination register (other than 0) and has not yet read its operands.
- R7: On the edge where a write grant is given, three things happen. The unit becomes free, so a new instruction for it may issue in the next cycle. The pending-writer record of its destination register is cleared. Waiting instructions that named this unit as a producer become ready, so their `start_o` can rise in the next cycle.
- R8: At most one bit of `wr_grant_o` is high in any cycle. Bit i stands for unit i. When several units are waiting to write, the lowest index is granted first.
- R9: After reset every unit is idle, `start_o` and `wr_grant_o` are zero, and `instr_ready_o` is high for any unit and destination.
- R10: `done_i` for a unit that is not executing is ignored: no write grant follows and the unit stays free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Queue head holds an instruction |
| instr_fu_i | input | FU_W | Index of the functional unit the instruction needs |
| instr_op_i | input | OP_W | Operation code passed to the unit |
| instr_rd_i | input | REG_W | Destination register |
| instr_rs1_i | input | REG_W | First source register |
| instr_rs2_i | input | REG_W | Second source register |
| instr_ready_o | output | 1 | Instruction can issue this cycle |
| start_o | output | NUM_FU | Per-unit grant to read operands and begin execution |
| fu_op_o | output | NUM_FU*OP_W | Per-unit operation code |
| fu_src1_o | output | NUM_FU*REG_W | Per-unit first source register |
| fu_src2_o | output | NUM_FU*REG_W | Per-unit second source register |
| done_i | input | NUM_FU | Per-unit pulse: execution finished |
| wr_grant_o | output | NUM_FU | One-hot write-back grant |
| wr_reg_o | output | REG_W | Destination register of the granted write |

## Verification
The hardest case to reach from the ports is a write-after-read hold. It needs a unit that has finished, whose destination is a source of an earlier instruction that is itself stalled on a different, slow producer. The stimulus builds this in a fixed order. It issues a multiply writing r8, then a divide that reads r8 and r9, then an add that writes r9. It completes the add at once and leaves the multiply running. The bench then confirms that the add gets no grant across several cycles. It also confirms that the add is still held in the cycle the divide starts, and that the add's grant arrives only after the divide has read its operands.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_EXEC,
    PH_DONE
  } sb_phase_e;
endpackage

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 32,
  localparam int FU_W    = $clog2(NUM_FU),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic [FU_W-1:0]  set_fu_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_reg_i,
  input  logic [FU_W-1:0]  clr_fu_i,
  input  logic [REG_W-1:0] q_rd_i,
  input  logic [REG_W-1:0] q_rs1_i,
  input  logic [REG_W-1:0] q_rs2_i,
  output logic             rd_pend_o,
  output logic             rs1_pend_o,
  output logic [FU_W-1:0]  rs1_fu_o,
  output logic             rs2_pend_o,
  output logic [FU_W-1:0]  rs2_fu_o
);
  logic            vld_q [NUM_REGS];
  logic [FU_W-1:0] fu_q  [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        vld_q[r] <= 1'b0;
        fu_q[r]  <= '0;
      end
    end else begin
      if (clr_en_i && clr_reg_i != '0 && fu_q[clr_reg_i] == clr_fu_i) vld_q[clr_reg_i] <= 1'b0;
      if (set_en_i && set_reg_i != '0) begin
        vld_q[set_reg_i] <= 1'b1;
        fu_q[set_reg_i]  <= set_fu_i;
      end
    end
  end

  assign rd_pend_o  = (q_rd_i  != '0) && vld_q[q_rd_i];
  assign rs1_pend_o = (q_rs1_i != '0) && vld_q[q_rs1_i];
  assign rs2_pend_o = (q_rs2_i != '0) && vld_q[q_rs2_i];
  assign rs1_fu_o   = fu_q[q_rs1_i];
  assign rs2_fu_o   = fu_q[q_rs2_i];

  AST_SET_FREE_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i && set_reg_i != '0 |-> !vld_q[set_reg_i]); // R1
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int FU_W  = 2,
  parameter int REG_W = 5,
  parameter int OP_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [REG_W-1:0] fi_i,
  input  logic [REG_W-1:0] fj_i,
  input  logic [REG_W-1:0] fk_i,
  input  logic [FU_W-1:0]  qj_i,
  input  logic [FU_W-1:0]  qk_i,
  input  logic             rj_i,
  input  logic             rk_i,
  input  logic             done_i,
  input  logic             wb_valid_i,
  input  logic [FU_W-1:0]  wb_fu_i,
  input  logic [REG_W-1:0] wb_reg_i,
  input  logic             wb_grant_i,
  output logic             busy_o,
  output logic             start_o,
  output logic             wr_req_o,
  output logic [OP_W-1:0]  op_o,
  output logic [REG_W-1:0] fi_o,
  output logic [REG_W-1:0] fj_o,
  output logic [REG_W-1:0] fk_o,
  output logic             rj_o,
  output logic             rk_o
);
  sb_phase_e        phase_q;
  logic [OP_W-1:0]  op_q;
  logic [REG_W-1:0] fi_q, fj_q, fk_q;
  logic [FU_W-1:0]  qj_q, qk_q;
  logic             rj_q, rk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      op_q    <= '0;
      fi_q    <= '0;
      fj_q    <= '0;
      fk_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else if (issue_i) begin
      phase_q <= PH_WAIT;
      op_q    <= op_i;
      fi_q    <= fi_i;
      fj_q    <= fj_i;
      fk_q    <= fk_i;
      qj_q    <= qj_i;
      qk_q    <= qk_i;
      rj_q    <= rj_i;
      rk_q    <= rk_i;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (rj_q && rk_q) begin
            phase_q <= PH_EXEC;
            rj_q    <= 1'b0;  // operands consumed: no WAR hold from here on
            rk_q    <= 1'b0;
          end else begin
            if (wb_valid_i && !rj_q && qj_q == wb_fu_i) rj_q <= 1'b1;
            if (wb_valid_i && !rk_q && qk_q == wb_fu_i) rk_q <= 1'b1;
          end
        end
        PH_EXEC: if (done_i) phase_q <= PH_DONE;
        PH_DONE: if (wb_grant_i) phase_q <= PH_IDLE;
        default: ;
      endcase
    end
  end

  assign busy_o   = phase_q != PH_IDLE;
  assign start_o  = phase_q == PH_WAIT && rj_q && rk_q;
  assign wr_req_o = phase_q == PH_DONE;
  assign op_o     = op_q;
  assign fi_o     = fi_q;
  assign fj_o     = fj_q;
  assign fk_o     = fk_q;
  assign rj_o     = rj_q;
  assign rk_o     = rk_q;

  AST_ISSUE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> phase_q == PH_IDLE); // R1
  AST_START_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R3
  AST_GRANT_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_grant_i |-> phase_q == PH_DONE); // R5
  AST_FREE_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_grant_i |=> !busy_o); // R7
  AST_NO_WAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i && !wb_grant_i && wb_reg_i != '0 && phase_q == PH_WAIT
    |-> !(rj_q && fj_q == wb_reg_i) && !(rk_q && fk_q == wb_reg_i)); // R6
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NUM_FU = 4,
  localparam int FU_W  = $clog2(NUM_FU)
) (
  input  logic [NUM_FU-1:0] req_i,
  output logic [NUM_FU-1:0] grant_o,
  output logic              valid_o,
  output logic [FU_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = FU_W'(i);
    end
  end

  assign valid_o = |req_i;
  assign grant_o = valid_o ? (NUM_FU'(1) << idx_o) : '0;
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU   = 4,
  parameter int NUM_REGS = 32,
  parameter int OP_W     = 4,
  localparam int FU_W    = $clog2(NUM_FU),
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    instr_valid_i,
  input  logic [FU_W-1:0]         instr_fu_i,
  input  logic [OP_W-1:0]         instr_op_i,
  input  logic [REG_W-1:0]        instr_rd_i,
  input  logic [REG_W-1:0]        instr_rs1_i,
  input  logic [REG_W-1:0]        instr_rs2_i,
  output logic                    instr_ready_o,
  output logic [NUM_FU-1:0]       start_o,
  output logic [NUM_FU*OP_W-1:0]  fu_op_o,
  output logic [NUM_FU*REG_W-1:0] fu_src1_o,
  output logic [NUM_FU*REG_W-1:0] fu_src2_o,
  input  logic [NUM_FU-1:0]       done_i,
  output logic [NUM_FU-1:0]       wr_grant_o,
  output logic [REG_W-1:0]        wr_reg_o
);
  logic [NUM_FU-1:0] busy_w, req_w, war_w, issue_w;
  logic [REG_W-1:0]  fi_w [NUM_FU];
  logic [REG_W-1:0]  fj_w [NUM_FU];
  logic [REG_W-1:0]  fk_w [NUM_FU];
  logic [NUM_FU-1:0] rj_w, rk_w, done_rdy_w;

  logic             rd_pend, rs1_pend, rs2_pend;
  logic [FU_W-1:0]  rs1_fu, rs2_fu;
  logic             wb_valid;
  logic [FU_W-1:0]  wb_idx;
  logic             fu_ok, fire, rs1_rdy, rs2_rdy;

  assign fu_ok         = 32'(instr_fu_i) < NUM_FU;
  assign instr_ready_o = fu_ok && !busy_w[instr_fu_i] && !rd_pend;
  assign fire          = instr_valid_i && instr_ready_o;

  // A producer writing back this cycle already delivers the value.
  assign rs1_rdy = !rs1_pend || (wb_valid && rs1_fu == wb_idx);
  assign rs2_rdy = !rs2_pend || (wb_valid && rs2_fu == wb_idx);

  sb_reg_status #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS)) u_reg_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (fire),
    .set_reg_i  (instr_rd_i),
    .set_fu_i   (instr_fu_i),
    .clr_en_i   (wb_valid),
    .clr_reg_i  (wr_reg_o),
    .clr_fu_i   (wb_idx),
    .q_rd_i     (instr_rd_i),
    .q_rs1_i    (instr_rs1_i),
    .q_rs2_i    (instr_rs2_i),
    .rd_pend_o  (rd_pend),
    .rs1_pend_o (rs1_pend),
    .rs1_fu_o   (rs1_fu),
    .rs2_pend_o (rs2_pend),
    .rs2_fu_o   (rs2_fu)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    assign issue_w[g] = fire && instr_fu_i == FU_W'(g);

    sb_fu_entry #(.FU_W(FU_W), .REG_W(REG_W), .OP_W(OP_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_w[g]),
      .op_i       (instr_op_i),
      .fi_i       (instr_rd_i),
      .fj_i       (instr_rs1_i),
      .fk_i       (instr_rs2_i),
      .qj_i       (rs1_fu),
      .qk_i       (rs2_fu),
      .rj_i       (rs1_rdy),
      .rk_i       (rs2_rdy),
      .done_i     (done_i[g]),
      .wb_valid_i (wb_valid),
      .wb_fu_i    (wb_idx),
      .wb_reg_i   (wr_reg_o),
      .wb_grant_i (wr_grant_o[g]),
      .busy_o     (busy_w[g]),
      .start_o    (start_o[g]),
      .wr_req_o   (done_rdy_w[g]),
      .op_o       (fu_op_o[g*OP_W +: OP_W]),
      .fi_o       (fi_w[g]),
      .fj_o       (fj_w[g]),
      .fk_o       (fk_w[g]),
      .rj_o       (rj_w[g]),
      .rk_o       (rk_w[g])
    );

    assign fu_src1_o[g*REG_W +: REG_W] = fj_w[g];
    assign fu_src2_o[g*REG_W +: REG_W] = fk_w[g];
  end

  // WAR: another entry still has to read the old value of our destination.
  always_comb begin
    war_w = '0;
    for (int f = 0; f < NUM_FU; f++) begin
      for (int h = 0; h < NUM_FU; h++) begin
        if (h != f && fi_w[f] != '0 &&
            ((rj_w[h] && fj_w[h] == fi_w[f]) || (rk_w[h] && fk_w[h] == fi_w[f])))
          war_w[f] = 1'b1;
      end
    end
  end

  assign req_w = done_rdy_w & ~war_w;

  sb_wb_arb #(.NUM_FU(NUM_FU)) u_wb_arb (
    .req_i   (req_w),
    .grant_o (wr_grant_o),
    .valid_o (wb_valid),
    .idx_o   (wb_idx)
  );

  assign wr_reg_o = fi_w[wb_idx];

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_grant_o)); // R8
  AST_NO_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid |=> !busy_w[$past(wb_idx)] || $past(fire && instr_fu_i == wb_idx)); // R7
endmodule

// File: tb/sb_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_ctrl_tb_top;
  localparam int NUM_FU = 4;
  localparam int FU_W   = 2;
  localparam int REG_W  = 5;
  localparam int OP_W   = 4;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    instr_valid = 1'b0;
  logic [FU_W-1:0]         instr_fu = '0;
  logic [OP_W-1:0]         instr_op = '0;
  logic [REG_W-1:0]        instr_rd = '0, instr_rs1 = '0, instr_rs2 = '0;
  logic                    instr_ready;
  logic [NUM_FU-1:0]       start, done = '0, wr_grant;
  logic [NUM_FU*OP_W-1:0]  fu_op;
  logic [NUM_FU*REG_W-1:0] fu_src1, fu_src2;
  logic [REG_W-1:0]        wr_reg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  sb_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid), .instr_fu_i(instr_fu), .instr_op_i(instr_op),
    .instr_rd_i(instr_rd), .instr_rs1_i(instr_rs1), .instr_rs2_i(instr_rs2),
    .instr_ready_o(instr_ready), .start_o(start), .fu_op_o(fu_op),
    .fu_src1_o(fu_src1), .fu_src2_o(fu_src2), .done_i(done),
    .wr_grant_o(wr_grant), .wr_reg_o(wr_reg)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_wb(int fu, int rd);
    exp_q.push_back(fu * 64 + rd);
  endtask

  task automatic issue(int fu, int rd, int rs1, int rs2, string req);
    instr_valid = 1'b1;
    instr_fu    = FU_W'(fu);
    instr_op    = OP_W'(fu + 1);
    instr_rd    = REG_W'(rd);
    instr_rs1   = REG_W'(rs1);
    instr_rs2   = REG_W'(rs2);
    #1;
    chk(instr_ready == 1'b1, req, int'(instr_ready), 1);
    step();
    instr_valid = 1'b0;
  endtask

  task automatic pulse_done(logic [NUM_FU-1:0] m);
    done = m;
    step();
    done = '0;
  endtask

  // Monitor: every write grant must match the next expected write-back.
  always @(negedge clk) begin
    if (rst_n && wr_grant != '0) begin
      int idx;
      idx = -1;
      for (int i = 0; i < NUM_FU; i++) if (wr_grant[i]) idx = (idx < 0) ? i : 99;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected grant", idx * 64 + int'(wr_reg), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(idx * 64 + int'(wr_reg) == e, "R8 grant order/reg", idx * 64 + int'(wr_reg), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk(start == '0, "R9 start", int'(start), 0);
    chk(wr_grant == '0, "R9 grant", int'(wr_grant), 0);
    instr_fu = 2'd3; instr_rd = 5'd20;
    #1;
    chk(instr_ready == 1'b1, "R9 ready", int'(instr_ready), 1);
    step();

    // RAW: add waits on multiply result r5
    issue(2, 5, 1, 2, "R1");
    chk(start[2] == 1'b1, "R3 start after issue", int'(start), 4);
    issue(1, 6, 5, 3, "R1");
    chk(start == '0, "R3 one pulse / RAW wait", int'(start), 0);
    expect_wb(2, 5);
    pulse_done(4'b0100);
    step();
    chk(start[1] == 1'b1, "R7 dependent released", int'(start), 2);
    step();
    expect_wb(1, 6);
    pulse_done(4'b0010);
    step();

    // WAR: add writing r9 held until divide reads r9
    issue(2, 8, 1, 2, "R1");
    issue(3, 7, 8, 9, "R1");
    issue(1, 9, 1, 2, "R1");
    chk(start[1] == 1'b1 && start[3] == 1'b0, "R4 out of order start", int'(start), 2);
    step();
    pulse_done(4'b0010);
    for (int i = 0; i < 3; i++) begin
      chk(wr_grant == '0, "R6 WAR hold", int'(wr_grant), 0);
      step();
    end
    expect_wb(2, 8);
    pulse_done(4'b0100);
    step();
    chk(start[3] == 1'b1, "R7 divide released", int'(start), 8);
    chk(wr_grant[1] == 1'b0, "R6 hold while reader starts", int'(wr_grant), 0);
    expect_wb(1, 9);
    step();
    step();
    expect_wb(3, 7);
    pulse_done(4'b1000);
    step();

    // WAW and structural stalls
    issue(2, 10, 1, 2, "R1");
    step();
    instr_valid = 1'b1; instr_fu = 2'd1; instr_rd = 5'd10; instr_rs1 = 5'd1; instr_rs2 = 5'd2;
    #1;
    chk(instr_ready == 1'b0, "R1 WAW stall", int'(instr_ready), 0);
    repeat (3) step();
    chk(instr_ready == 1'b0 && start == '0, "R1 WAW nothing taken", int'(start), 0);
    instr_fu = 2'd2; instr_rd = 5'd14;
    #1;
    chk(instr_ready == 1'b0, "R1 structural stall", int'(instr_ready), 0);
    step();
    instr_valid = 1'b0;
    expect_wb(2, 10);
    pulse_done(4'b0100);
    step();
    issue(1, 10, 3, 4, "R7 reg freed");
    issue(2, 14, 3, 4, "R7 unit freed");
    step();
    expect_wb(1, 10);
    expect_wb(2, 14);
    pulse_done(4'b0110);
    repeat (3) step();

    // Register 0 and simultaneous completion
    issue(2, 0, 1, 2, "R2");
    issue(1, 0, 0, 0, "R2 dest0 no WAW");
    issue(0, 11, 0, 0, "R2");
    chk(start[0] == 1'b1, "R2 source0 ready", int'(start), 1);
    step();
    expect_wb(0, 11);
    expect_wb(1, 0);
    expect_wb(2, 0);
    pulse_done(4'b0111);
    repeat (4) step();

    // done to idle unit is ignored
    pulse_done(4'b1000);
    for (int i = 0; i < 3; i++) begin
      chk(wr_grant == '0, "R10 stray done", int'(wr_grant), 0);
      step();
    end
    issue(3, 15, 1, 2, "R10 unit still free");
    step();
    expect_wb(3, 15);
    pulse_done(4'b1000);
    repeat (3) step();

    chk(exp_q.size() == 0, "R5 missing grants", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule